// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal. It counts the rising edges of that signal during a gate window whose length is a whole number of reference-clock cycles. A single start strobe opens the window. The caller picks one of four window lengths with a 2-bit code. When the window closes, the count freezes and a done flag comes up. The count can then be read in parallel or shifted out serially on one data pin, most significant bit first.

The whole block runs on the reference clock, nominally 75 kHz. The IF input arrives without a prescaler. It is brought into the reference domain through a multi-flop synchronizer, and each rising edge seen there is counted once. The serial data pin is shared. A 3-bit selector decides whether it carries the shifted count, the done flag, the busy flag or a steady low level.

Top module: `if_gate_counter`

## Requirements
- R1: After a synchronous reset, `busy` is 0, `done` is 0, `count` is 0 and `sdo` is 0.
- R2: A `start` pulse taken while idle raises `busy` on the next clock edge, clears `count` to 0 and clears `done`.
- R3: `busy` stays high for exactly BASE_TICKS × M reference cycles. M is 1, 2, 8 and 16 for `gate_sel` 00, 01, 10 and 11, which gives 4, 8, 32 and 64 ms at 75 kHz with BASE_TICKS = 300.
- R4: Every rising edge of `if_in` whose synchronized copy lands inside the gate adds exactly one to `count`.
- R5: Edges of `if_in` outside the gate have no effect. After the gate closes, `count` holds its value until the next accepted start.
- R6: `done` is still 0 in the cycle in which `busy` falls, goes to 1 one cycle later, and stays 1 until the next accepted start.
- R7: A `start` pulse is ignored while `busy` is high, and also in the closing cycle right after `busy` falls.
- R8: With `out_sel` = 3'b001, a `shift_load` pulse puts `count[CNT_W-1]` on `sdo`. Each `shift_step` pulse after that presents the next lower bit.
- R9: `out_sel` = 3'b010 puts `done` on `sdo` and 3'b011 puts `busy` on `sdo`. 3'b000 and every code from 3'b100 upward drive `sdo` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| if_in | input | 1 | IF signal to be counted |
| start | input | 1 | Measurement start strobe |
| gate_sel | input | 2 | Gate length code |
| out_sel | input | 3 | Serial output source select |
| shift_load | input | 1 | Load the count into the shift register |
| shift_step | input | 1 | Advance the shift register by one bit |
| count | output | CNT_W | Edge count of the last or running gate |
| busy | output | 1 | Gate window open |
| done | output | 1 | Measurement finished, count valid |
| sdo | output | 1 | Serial data output |

## Verification
Two events can fall on the same clock edge: a new start request and the completion of the previous gate. The bench raises `start` in exactly the cycle after `busy` drops, which is the closing cycle. It then requires three things: `done` rises on schedule, `busy` stays low, and the frozen count is untouched. A second start is also fired in the middle of an open gate. The bench then checks that the measured gate length and the final count match a run with no interference.

// File: rtl/if_gate_pkg.sv
package if_gate_pkg;

  typedef enum logic [2:0] {
    OSEL_OFF   = 3'd0,
    OSEL_COUNT = 3'd1,
    OSEL_DONE  = 3'd2,
    OSEL_BUSY  = 3'd3
  } osel_e;

  // Gate length multiplier over the base window for each select code
  function automatic int unsigned gate_mult(input logic [1:0] code);
    case (code)
      2'b00:   gate_mult = 1;
      2'b01:   gate_mult = 2;
      2'b10:   gate_mult = 8;
      default: gate_mult = 16;
    endcase
  endfunction

endpackage

// File: rtl/if_edge_sync.sv
module if_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int PW = STAGES + 1;

  logic [PW-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[PW-2:0], din};
  end

  // Newest synchronized sample high, previous one low
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];

  a_r4_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/if_gate_timer.sv
module if_gate_timer #(
  parameter int BASE_TICKS = 300
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] gate_sel,
  output logic       accept,
  output logic       busy,
  output logic       done
);
  import if_gate_pkg::*;

  localparam int MAX_LEN = BASE_TICKS * 16;
  localparam int TW      = $clog2(MAX_LEN + 1);

  logic [TW-1:0] tick;
  logic [TW-1:0] len_q;
  logic          closing;

  assign accept = start & ~busy & ~closing;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      closing <= 1'b0;
      done    <= 1'b0;
      tick    <= '0;
      len_q   <= '0;
    end else begin
      closing <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        done  <= 1'b0;
        tick  <= '0;
        len_q <= TW'(BASE_TICKS * gate_mult(gate_sel));
      end else if (busy) begin
        if (tick == len_q - 1'b1) begin
          busy    <= 1'b0;
          closing <= 1'b1;
        end else begin
          tick <= tick + 1'b1;
        end
      end
      if (closing) done <= 1'b1;
    end
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy && !done);
  a_r6_done_after_close: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |=> done);
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  a_r7_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |-> !accept);
  a_r3_tick_in_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (tick < len_q));
endmodule

// File: rtl/if_edge_counter.sv
module if_edge_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             gate,
  input  logic             rise,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)               count <= '0;
    else if (accept)       count <= '0;
    else if (gate && rise) count <= count + 1'b1;
  end

  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    (gate && rise && !accept) |=> count == CNT_W'($past(count) + 1'b1));
  a_r5_frozen_outside: assert property (@(posedge clk) disable iff (rst)
    (!gate && !accept) |=> $stable(count));
  a_r2_cleared_on_start: assert property (@(posedge clk) disable iff (rst)
    accept |=> count == '0);
endmodule

// File: rtl/if_serial_out.sv
module if_serial_out #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       out_sel,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] count,
  input  logic             done,
  input  logic             busy,
  output logic             sdo
);
  import if_gate_pkg::*;

  logic [CNT_W-1:0] sreg;
  logic [CNT_W-1:0] sreg_nxt;
  logic             sdo_nxt;

  always_comb begin
    if (load)      sreg_nxt = count;
    else if (step) sreg_nxt = {sreg[CNT_W-2:0], 1'b0};
    else           sreg_nxt = sreg;
  end

  always_comb begin
    case (osel_e'(out_sel))
      OSEL_COUNT: sdo_nxt = sreg_nxt[CNT_W-1];
      OSEL_DONE:  sdo_nxt = done;
      OSEL_BUSY:  sdo_nxt = busy;
      default:    sdo_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      sdo  <= 1'b0;
    end else begin
      sreg <= sreg_nxt;
      sdo  <= sdo_nxt;
    end
  end

  a_r8_msb_on_load: assert property (@(posedge clk) disable iff (rst)
    (out_sel == 3'd1 && load) |=> sdo == $past(count[CNT_W-1]));
  a_r8_next_bit: assert property (@(posedge clk) disable iff (rst)
    (out_sel == 3'd1 && step && !load) |=> sdo == $past(sreg[CNT_W-2]));
  a_r9_quiet_codes: assert property (@(posedge clk) disable iff (rst)
    (out_sel == 3'd0 || out_sel[2]) |=> !sdo);
endmodule

// File: rtl/if_gate_counter.sv
module if_gate_counter #(
  parameter int BASE_TICKS  = 300,
  parameter int CNT_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             if_in,
  input  logic             start,
  input  logic [1:0]       gate_sel,
  input  logic [2:0]       out_sel,
  input  logic             shift_load,
  input  logic             shift_step,
  output logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             done,
  output logic             sdo
);
  logic rise;
  logic accept;

  if_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(if_in), .rise(rise)
  );

  if_gate_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
    .clk(clk), .rst(rst), .start(start), .gate_sel(gate_sel),
    .accept(accept), .busy(busy), .done(done)
  );

  if_edge_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .accept(accept), .gate(busy),
    .rise(rise), .count(count)
  );

  if_serial_out #(.CNT_W(CNT_W)) u_ser (
    .clk(clk), .rst(rst), .out_sel(out_sel), .load(shift_load),
    .step(shift_step), .count(count), .done(done), .busy(busy), .sdo(sdo)
  );
endmodule

// File: tb/if_gate_counter_bench.sv
module if_gate_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 300;
  localparam int CW         = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          if_in = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    gate_sel = 2'b00;
  logic [2:0]    out_sel = 3'b000;
  logic          shift_load = 1'b0;
  logic          shift_step = 1'b0;
  logic [CW-1:0] count;
  logic          busy, done, sdo;

  int checks = 0;
  int errors = 0;
  int busy_len = 0;
  bit finished = 1'b0;

  if_gate_counter #(.BASE_TICKS(BASE), .CNT_W(CW), .SYNC_STAGES(2)) u_if_gate_counter (
    .clk(clk), .rst(rst), .if_in(if_in), .start(start), .gate_sel(gate_sel),
    .out_sel(out_sel), .shift_load(shift_load), .shift_step(shift_step),
    .count(count), .busy(busy), .done(done), .sdo(sdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (busy) busy_len++;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) if_in = 1'b1;
      @(negedge clk);
      @(negedge clk) if_in = 1'b0;
      @(negedge clk);
    end
  endtask

  function automatic int mult(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 8;
      default: return 16;
    endcase
  endfunction

  // One measurement; optional start pokes mid-gate and in the closing cycle
  task automatic do_gate(input logic [1:0] sel, input int npulse,
                         input bit poke_mid, input bit poke_close);
    gate_sel = sel;
    @(negedge clk) start = 1'b1; busy_len = 0;
    @(negedge clk) start = 1'b0;
    check("R2 busy after start", busy, 1);
    check("R2 count cleared", count, 0);
    check("R2 done cleared", done, 0);
    repeat (4) @(negedge clk);
    pulses(npulse);
    if (poke_mid) begin
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      check("R7 mid-gate start keeps busy", busy, 1);
    end
    while (busy) @(negedge clk);
    check("R6 done low in closing cycle", done, 0);
    if (poke_close) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 done one cycle after close", done, 1);
    check("R7 start in closing cycle ignored", busy, 0);
    check("R3 gate length", busy_len, BASE * mult(sel));
    check("R4 edges counted", count, npulse);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy reset", busy, 0);
    check("R1 done reset", done, 0);
    check("R1 count reset", count, 0);
    check("R1 sdo reset", sdo, 0);
  endtask

  task automatic t_outside();
    logic [CW-1:0] held;
    held = count;
    pulses(6);
    repeat (4) @(negedge clk);
    check("R5 count frozen after gate", count, held);
    check("R6 done holds", done, 1);
    check("R5 stays idle", busy, 0);
  endtask

  task automatic t_serial(input logic [CW-1:0] exp);
    logic [CW-1:0] word;
    out_sel = 3'b001;
    @(negedge clk) shift_load = 1'b1;
    @(negedge clk) shift_load = 1'b0;
    word[CW-1] = sdo;
    for (int b = CW - 2; b >= 0; b--) begin
      shift_step = 1'b1;
      @(negedge clk);
      word[b] = sdo;
    end
    shift_step = 1'b0;
    check("R8 serial word MSB first", word, exp);
  endtask

  task automatic t_flags();
    out_sel = 3'b010; @(negedge clk); @(negedge clk);
    check("R9 done on sdo", sdo, done);
    out_sel = 3'b011; @(negedge clk); @(negedge clk);
    check("R9 busy on sdo idle", sdo, 0);
    out_sel = 3'b101; @(negedge clk); @(negedge clk);
    check("R9 unused code low", sdo, 0);
    out_sel = 3'b000; @(negedge clk); @(negedge clk);
    check("R9 off code low", sdo, 0);
    out_sel = 3'b011;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    check("R9 busy on sdo during gate", sdo, 1);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    t_reset();
    do_gate(2'b00, 40, 1'b0, 1'b0);
    t_serial(CW'(40));
    t_outside();
    do_gate(2'b01, 100, 1'b1, 1'b0);
    t_serial(CW'(100));
    do_gate(2'b10, 30, 1'b0, 1'b1);
    t_outside();
    do_gate(2'b11, 7, 1'b1, 1'b1);
    t_serial(CW'(7));
    t_flags();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule